// File: doc/BRIEF.md
# Serial Register-Access Slave with Burst Transfers

This block is the slave end of a four-wire serial control port. A host lowers chip select, toggles the serial clock and shifts bytes in on the data input. The block uses those bytes to read or write a small byte-wide register file that it holds itself. Each transaction opens with two header bytes. The first is the start address. The second is a command byte: its top bit selects read or write and its low seven bits give a byte count. After the header comes a burst of that many data bytes, at addresses that step up by one each time. The address wraps at the end of the register file.

A single mode input sets the bit order for every byte on the wire, header bytes and data bytes alike: most-significant bit first or least-significant bit first. The host may keep chip select low for the whole transaction, or raise it between bytes. Either way the block keeps its bit and header position, so no extra framing signal is needed.

The serial pins are sampled on the block's own clock. This clock must run fast enough to see every level of the serial clock, and the serial inputs are treated as synchronous to it. Clock edges that arrive while chip select is high still move the shifter, so a host must toggle the serial clock only while chip select is low.

Top module: `spi_block_slave`

## Requirements
- R1: The serial input is captured on each rising edge of the serial clock, and eight captured bits form one byte.
- R2: With `msb_first` = 1 every byte is shifted most-significant bit first. With `msb_first` = 0 every byte, header included, is shifted least-significant bit first.
- R3: The first header byte is the start address. In the second header byte, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6:0 hold the byte count (0x83 = read three bytes).
- R4: Data bytes use the start address, then start+1, start+2 and so on. A written byte is stored only once all eight of its bits have arrived.
- R5: Only the low log2(DEPTH) bits of the address byte are used, and incrementing wraps from DEPTH-1 to 0.
- R6: A byte count of zero skips the data phase. The byte after that command byte is taken as a new start address.
- R7: During a read data phase, `sdo` changes only after a falling serial-clock edge. Bit k of the current byte (in the selected order) is valid before the k-th rising edge of that byte, and `sdo_oe` is 1.
- R8: While `cs_n` is high, `sdo` and `sdo_oe` are 0. Raising `cs_n` between bytes does not lose the transaction position.
- R9: A rising serial-clock edge while `cs_n` is high still advances the bit shifter.
- R10: A synchronous active-high reset clears the bit position, returns the header sequencer to expect-address, and clears every register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| msb_first | input | 1 | 1 = most-significant bit first, 0 = least-significant bit first |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host, 0 when not driving |
| sdo_oe | output | 1 | High while `sdo` carries read data |

## Verification
Bursts are written and read back with chip select held low and with chip select pulsed for each byte, in both bit orders. Writing in one order and reading in the other shows that the order setting affects only the wire format, not the stored values. A burst that starts near the top of the register file, with junk in the upper address bits, exposes wrapping errors. A zero-count command followed at once by a second header shows whether the sequencer really skips the data phase. A stray clock edge while chip select is high, followed by seven bits, shows that the shifter runs ungated. A mid-run reset followed by a full read shows that every register is cleared.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    typedef struct packed {
        logic       rd;
        logic [6:0] cnt;
    } cmd_t;

    // Shift one wire bit into a partially assembled byte.
    function automatic logic [7:0] shift_in(input logic [7:0] cur,
                                            input logic       b,
                                            input logic       msb);
        return msb ? {cur[6:0], b} : {b, cur[7:1]};
    endfunction

    // Pick the wire bit at position idx of a byte for the chosen order.
    function automatic logic pick_bit(input logic [7:0] v,
                                      input logic [2:0] idx,
                                      input logic       msb);
        return msb ? v[3'd7 - idx] : v[idx];
    endfunction

endpackage

// File: rtl/spi_sclk_edges.sv
module spi_sclk_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
    import spi_blk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       sdi,
    input  logic       msb_first,
    output logic [2:0] bit_idx,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    logic [7:0] shreg;

    assign byte_val  = shift_in(shreg, sdi, msb_first);
    assign byte_done = rise && (bit_idx == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (rise) begin
            shreg   <= byte_val;
            bit_idx <= bit_idx + 3'd1;
        end
    end
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
    import spi_blk_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_done,
    input  logic [7:0]    byte_val,
    output phase_t        phase,
    output logic [AW-1:0] cur_addr,
    output logic          rd_mode,
    output logic          wr_en
);
    cmd_t       cmd_in;
    logic [6:0] remain;

    assign cmd_in = cmd_t'(byte_val);
    assign wr_en  = byte_done && (phase == PH_DATA) && !rd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_ADDR;
            cur_addr <= '0;
            rd_mode  <= 1'b0;
            remain   <= '0;
        end else if (byte_done) begin
            unique case (phase)
                PH_ADDR: begin
                    cur_addr <= byte_val[AW-1:0];
                    phase    <= PH_CMD;
                end
                PH_CMD: begin
                    rd_mode <= cmd_in.rd;
                    remain  <= cmd_in.cnt;
                    phase   <= (cmd_in.cnt == 7'd0) ? PH_ADDR : PH_DATA;
                end
                PH_DATA: begin
                    cur_addr <= cur_addr + AW'(1);
                    remain   <= remain - 7'd1;
                    if (remain == 7'd1) phase <= PH_ADDR;
                end
                default: phase <= PH_ADDR;
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    logic [7:0] regs [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                                  regs[i] <= 8'h00;
                else if (wr_en && (addr == AW'(i)))       regs[i] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = regs[addr];
endmodule

// File: rtl/spi_block_slave.sv
module spi_block_slave
    import spi_blk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic msb_first,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic          rise, fall;
    logic [2:0]    bit_idx;
    logic          byte_done;
    logic [7:0]    byte_val;
    phase_t        phase;
    logic [AW-1:0] cur_addr;
    logic          rd_mode;
    logic          wr_en;
    logic [7:0]    rd_data;
    logic          sdo_r;

    spi_sclk_edges u_edges (
        .clk (clk), .rst (rst), .sclk (sclk), .rise (rise), .fall (fall)
    );

    spi_bit_shifter u_shift (
        .clk (clk), .rst (rst), .rise (rise), .sdi (sdi),
        .msb_first (msb_first), .bit_idx (bit_idx),
        .byte_done (byte_done), .byte_val (byte_val)
    );

    spi_txn_ctrl #(.AW(AW)) u_ctrl (
        .clk (clk), .rst (rst), .byte_done (byte_done), .byte_val (byte_val),
        .phase (phase), .cur_addr (cur_addr), .rd_mode (rd_mode), .wr_en (wr_en)
    );

    spi_reg_array #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (cur_addr),
        .wr_data (byte_val), .rd_data (rd_data)
    );

    // Read data leaves on the falling edge so it is settled for the next rise.
    always_ff @(posedge clk) begin
        if (rst)
            sdo_r <= 1'b0;
        else if (fall && !cs_n && (phase == PH_DATA) && rd_mode)
            sdo_r <= pick_bit(rd_data, bit_idx, msb_first);
    end

    assign sdo_oe = !cs_n && (phase == PH_DATA) && rd_mode;
    assign sdo    = sdo_oe ? sdo_r : 1'b0;
endmodule

// File: rtl/spi_block_slave_chk.sv
module spi_block_slave_chk
    import spi_blk_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          sclk,
    input logic          sdo,
    input logic          sdo_oe,
    input phase_t        phase,
    input logic [2:0]    bit_idx,
    input logic          byte_done,
    input logic [7:0]    byte_val,
    input logic [AW-1:0] cur_addr,
    input logic          rd_mode,
    input logic          wr_en
);
    p_idle_out_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sdo && !sdo_oe));

    p_sdo_moves_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && sdo_oe && $past(sdo_oe)
         && !(!$past(sclk) && $past(sclk, 2))) |-> $stable(sdo));

    p_no_write_in_read_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && rd_mode) |-> !wr_en);

    p_zero_count_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == PH_CMD && byte_val[6:0] == 7'd0) |=> (phase == PH_ADDR));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == PH_DATA) |=> (cur_addr == AW'($past(cur_addr) + AW'(1))));

    p_reset_state_r10: assert property (@(posedge clk)
        $past(rst) |-> (phase == PH_ADDR && bit_idx == 3'd0 && !sdo_oe));
endmodule

bind spi_block_slave spi_block_slave_chk #(.AW(AW)) u_chk (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .sdo (sdo),
    .sdo_oe (sdo_oe), .phase (phase), .bit_idx (bit_idx),
    .byte_done (byte_done), .byte_val (byte_val), .cur_addr (cur_addr),
    .rd_mode (rd_mode), .wr_en (wr_en)
);

// File: tb/spi_block_slave_test.sv
`timescale 1ns/1ps
module spi_block_slave_test;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msb_first = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [7:0] model [DEPTH];
    logic [7:0] wbuf  [DEPTH];

    always #4 clk = ~clk;

    spi_block_slave #(.DEPTH(DEPTH)) uut (
        .clk (clk), .rst (rst), .msb_first (msb_first), .cs_n (cs_n),
        .sclk (sclk), .sdi (sdi), .sdo (sdo), .sdo_oe (sdo_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every clock: with chip select high the output pins must be quiet (R8).
    always @(posedge clk) begin
        #2;
        if (!rst && !done && cs_n) check(!sdo && !sdo_oe, "R8 idle", {sdo_oe, sdo}, 0);
    end

    task automatic bit_xfer(input logic b, output logic got, output logic oe);
        @(negedge clk); sclk = 1'b0; sdi = b;
        repeat (2) @(negedge clk);
        got = sdo; oe = sdo_oe;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic pulse, input logic exp_oe,
                             input string req, output logic [7:0] got);
        logic g, oe, all_oe;
        all_oe = 1'b1;
        got = '0;
        if (pulse) begin @(negedge clk); cs_n = 1'b0; end
        for (int i = 0; i < 8; i++) begin
            int pos;
            pos = msb_first ? 7 - i : i;
            bit_xfer(v[pos], g, oe);
            got[pos] = g;
            all_oe &= oe;
        end
        if (exp_oe) check(all_oe, {req, " R7 oe"}, all_oe, 1);
        if (pulse) begin @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk); end
    endtask

    task automatic txn(input logic [7:0] a, input logic rd, input int n,
                       input logic pulse, input logic keep, input string req);
        logic [7:0] g;
        if (!pulse) begin @(negedge clk); cs_n = 1'b0; end
        send_byte(a, pulse, 1'b0, req, g);
        send_byte({rd, 7'(n)}, pulse, 1'b0, req, g);
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = (int'(a) + k) % DEPTH;
            if (rd) begin
                send_byte(8'h00, pulse, 1'b1, req, g);
                check(g == model[idx], req, g, model[idx]);
            end else begin
                send_byte(wbuf[k], pulse, 1'b0, req, g);
                model[idx] = wbuf[k];
            end
        end
        if (!pulse && !keep) begin @(negedge clk); cs_n = 1'b1; end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cs_n = 1'b1; sclk = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] g;
        logic b, oe;
        do_reset();

        // R10: outputs and every register cleared after reset
        check(!sdo && !sdo_oe, "R10 outputs", {sdo_oe, sdo}, 0);
        txn(8'h00, 1'b1, DEPTH, 1'b0, 1'b0, "R10 clear");

        // R1 R3 R4: MSB-first burst write held cs, read back
        msb_first = 1'b1;
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hA1 + 8'(k * 17);
        txn(8'h02, 1'b0, 4, 1'b0, 1'b0, "R4 write");
        txn(8'h02, 1'b1, 4, 1'b0, 1'b0, "R1 R3 readback");
        txn(8'h03, 1'b1, 3, 1'b1, 1'b0, "R8 pulsed read");

        // R2: LSB-first write with per-byte cs, read in both orders
        msb_first = 1'b0;
        wbuf[0] = 8'h81; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        txn(8'h08, 1'b0, 3, 1'b1, 1'b0, "R2 lsb write");
        txn(8'h08, 1'b1, 3, 1'b0, 1'b0, "R2 lsb read");
        msb_first = 1'b1;
        txn(8'h08, 1'b1, 3, 1'b1, 1'b0, "R2 msb read of lsb data");

        // R5: upper address bits ignored, wrap from 15 to 0
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h99;
        txn(8'hEE, 1'b0, 3, 1'b0, 1'b0, "R5 wrap write");
        txn(8'h0E, 1'b1, 4, 1'b0, 1'b0, "R5 wrap read");

        // R6: zero count, next byte is a fresh address under the same cs
        wbuf[0] = 8'h77;
        txn(8'h0A, 1'b0, 0, 1'b0, 1'b1, "R6 zero count");
        txn(8'h0B, 1'b0, 1, 1'b0, 1'b0, "R6 follow-on write");
        txn(8'h09, 1'b1, 4, 1'b0, 1'b0, "R6 check");
        txn(8'h04, 1'b1, 0, 1'b0, 1'b0, "R6 zero read");
        check(!sdo_oe, "R6 no read phase", sdo_oe, 0);

        // R9: stray edge with cs high counts as the first address bit
        msb_first = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        bit_xfer(1'b1, b, oe);
        @(negedge clk); cs_n = 1'b0;
        for (int i = 6; i >= 0; i--) bit_xfer(((7'b0000101 >> i) & 7'd1) != 0, b, oe);
        send_byte(8'h01, 1'b0, 1'b0, "R9", g);
        send_byte(8'h3C, 1'b0, 1'b0, "R9", g);
        @(negedge clk); cs_n = 1'b1;
        model[5] = 8'h3C;
        repeat (3) @(negedge clk);
        txn(8'h05, 1'b1, 1, 1'b0, 1'b0, "R9 stray edge");

        // R10: reset in mid-run clears the stored data
        do_reset();
        txn(8'h00, 1'b1, DEPTH, 1'b1, 1'b0, "R10 clear after use");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule